// File: doc/BRIEF.md
# Magic-Read Command Unlock Detector

This block watches the access strobes of a parallel, asynchronous-SRAM-style host bus, after they have been brought into the core clock domain. Each bus access reaches it as a one-cycle strobe with an address and a write flag. A read strobe may come from either the chip-enable path or the output-enable path. The block looks for one fixed run of six reads. The first five reads go to five fixed addresses. The sixth read goes to one of two addresses, and that address picks the command: a store request or a recall request.

The reads that make up the run still complete as normal array reads elsewhere in the chip. This block only issues the command. When the sixth read matches, it sends a one-cycle request to the sequencer and raises a flag that blocks host I/O. The flag stays up until the sequencer has reported busy and then dropped busy. A write, or a read to any unexpected address, cancels a partial run. Bus cycles that carry no strobe do not affect the run.

Top module: `unlock_seq_detect`

## Requirements
- R1: `step_o` gives the number of prefix reads matched so far (0 to 5). A request is issued only by a sixth read that arrives while `step_o` is 5. Cycles with no strobe leave `step_o` unchanged.
- R2: The prefix reads must come in this order: 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F. Each matching read raises `step_o` by one at the next clock edge.
- R3: When `step_o` is 5, a read at 0x0FC0 makes `store_req_o` high for exactly one cycle, starting at the next edge. At that same edge `step_o` returns to 0.
- R4: When `step_o` is 5, a read at 0x0C63 makes `recall_req_o` high for exactly one cycle, starting at the next edge. At that same edge `step_o` returns to 0. The two requests are never high together.
- R5: An access with `we_i` high returns `step_o` to 0 and issues no request, whatever its address is, including 0x0FC0 at step 5.
- R6: A read that does not match the expected address returns `step_o` to 0 and issues no request. The exception is a non-matching read at 0x0E38, which sets `step_o` to 1.
- R7: A strobe on `ce_acc_i`, on `oe_acc_i`, or on both in the same cycle counts as one access.
- R8: `io_block_o` rises at the same edge as a request pulse. It stays high until `busy_i` has been seen high and then seen low. While `io_block_o` is high, accesses are ignored and `step_o` stays 0.
- R9: While `busy_i` is high, accesses are ignored and `step_o` is 0 from the next edge on.
- R10: During reset, `step_o`, `store_req_o`, `recall_req_o` and `io_block_o` are all 0. Asserting reset part-way through a run clears `step_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_acc_i | input | 1 | Access strobe from the chip-enable path, one cycle per access |
| oe_acc_i | input | 1 | Access strobe from the output-enable path, one cycle per access |
| we_i | input | 1 | Write flag of the current access |
| addr_i | input | 15 | Address of the current access |
| busy_i | input | 1 | Sequencer is running a store or a recall |
| step_o | output | 3 | Number of prefix reads matched so far |
| store_req_o | output | 1 | One-cycle store command |
| recall_req_o | output | 1 | One-cycle recall command |
| io_block_o | output | 1 | Host I/O blocked after a command is issued |

## Verification
The hardest states to reach from the ports are the step-5 branches. Getting there takes five clean reads in order with no intervening access, and only then can a wrong sixth read, a write, or a re-start at 0x0E38 be tried. A single vector table walks full runs repeatedly and places the disturbing access at step 5 as well as at earlier steps. The blocked window after a command is driven cycle by cycle through busy low, busy high and busy low again. An access is placed inside that window to show it is ignored.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int ADDR_W     = 15;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [ADDR_W-1:0] STORE_ADDR  = 15'h0FC0;
  localparam logic [ADDR_W-1:0] RECALL_ADDR = 15'h0C63;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
    case (idx)
      0:       return 15'h0E38;
      1:       return 15'h31C7;
      2:       return 15'h03E0;
      3:       return 15'h3C1F;
      default: return 15'h303F;
    endcase
  endfunction
endpackage

// File: rtl/unlock_match.sv
module unlock_match
  import unlock_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_next_o,
  output logic              hit_first_o,
  output cmd_e              cmd_o
);
  logic [PREFIX_LEN-1:0] eq;

  for (genvar k = 0; k < PREFIX_LEN; k++) begin : g_cmp
    assign eq[k] = (addr_i == prefix_addr(k));
  end

  always_comb begin
    hit_next_o = 1'b0;
    for (int k = 0; k < PREFIX_LEN; k++)
      if (step_i == STEP_W'(k)) hit_next_o = eq[k];
  end

  assign hit_first_o = eq[0];

  always_comb begin
    cmd_o = CMD_NONE;
    if (step_i == STEP_W'(PREFIX_LEN)) begin
      if (addr_i == STORE_ADDR)       cmd_o = CMD_STORE;
      else if (addr_i == RECALL_ADDR) cmd_o = CMD_RECALL;
    end
  end
endmodule

// File: rtl/unlock_track.sv
module unlock_track
  import unlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic              halt_i,
  input  logic              hit_next_i,
  input  logic              hit_first_i,
  input  cmd_e              cmd_i,
  output logic              fire_o,
  output logic [STEP_W-1:0] step_o,
  output logic              store_o,
  output logic              recall_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);

  logic [STEP_W-1:0] step_q;
  logic              store_q, recall_q;
  logic              rd;

  assign rd     = acc_i && !we_i && !halt_i;
  assign fire_o = rd && (cmd_i != CMD_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      store_q  <= 1'b0;
      recall_q <= 1'b0;
      if (halt_i || (acc_i && we_i)) begin
        step_q <= '0;
      end else if (rd) begin
        if (cmd_i != CMD_NONE) begin
          store_q  <= (cmd_i == CMD_STORE);
          recall_q <= (cmd_i == CMD_RECALL);
          step_q   <= '0;
        end else if (hit_next_i && step_q != LAST) begin
          step_q <= step_q + 1'b1;
        end else begin
          // mismatch: a read at the first address restarts the run
          step_q <= hit_first_i ? STEP_W'(1) : '0;
        end
      end
    end
  end

  assign step_o   = step_q;
  assign store_o  = store_q;
  assign recall_o = recall_q;

  // R3
  store_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_q |=> !store_q);
  // R4
  recall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_q |=> !recall_q);
  // R1
  req_after_full_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(store_q) || $rose(recall_q) |-> $past(step_q) == LAST);
  // R5
  write_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && we_i |=> step_q == '0 && !store_q && !recall_q);
  // R9
  busy_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> step_q == '0 && !store_q && !recall_q);
endmodule

// File: rtl/unlock_hold.sv
module unlock_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic busy_i,
  output logic blk_o
);
  logic blk_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (fire_i) begin
      blk_q  <= 1'b1;
      seen_q <= 1'b0;
    end else if (blk_q) begin
      if (busy_i)      seen_q <= 1'b1;
      else if (seen_q) begin
        blk_q  <= 1'b0;
        seen_q <= 1'b0;
      end
    end
  end

  assign blk_o = blk_q;

  // R8
  hold_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blk_q) |-> $past(seen_q) && !$past(busy_i));
endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect
  import unlock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_acc_i,
  input  logic              oe_acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic [STEP_W-1:0] step_o,
  output logic              store_req_o,
  output logic              recall_req_o,
  output logic              io_block_o
);
  logic acc, halt, hit_next, hit_first, fire, blk;
  cmd_e cmd;

  assign acc  = ce_acc_i | oe_acc_i;
  assign halt = busy_i | blk;

  unlock_match i_match (
    .step_i      (step_o),
    .addr_i      (addr_i),
    .hit_next_o  (hit_next),
    .hit_first_o (hit_first),
    .cmd_o       (cmd)
  );

  unlock_track i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .we_i        (we_i),
    .halt_i      (halt),
    .hit_next_i  (hit_next),
    .hit_first_i (hit_first),
    .cmd_i       (cmd),
    .fire_o      (fire),
    .step_o      (step_o),
    .store_o     (store_req_o),
    .recall_o    (recall_req_o)
  );

  unlock_hold i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .busy_i (busy_i),
    .blk_o  (blk)
  );

  assign io_block_o = blk;

  // R4
  req_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_req_o, recall_req_o}));
  // R8
  req_blocks_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o || recall_req_o |-> io_block_o);
  // R8
  blocked_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_block_o |-> step_o == '0);
endmodule

// File: tb/test_unlock_seq_detect.sv
module test_unlock_seq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 29;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_acc_i = 1'b0, oe_acc_i = 1'b0, we_i = 1'b0, busy_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [2:0]  step_o;
  logic        store_req_o, recall_req_o, io_block_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  unlock_seq_detect i_unlock_seq_detect (
    .clk_i, .rst_ni, .ce_acc_i, .oe_acc_i, .we_i, .addr_i, .busy_i,
    .step_o, .store_req_o, .recall_req_o, .io_block_o
  );

  // fields: req, ce, oe, we, busy, addr, exp step, exp store, exp recall, exp block
  function automatic logic [VW-1:0] v(input int rq, input bit ce, input bit oe,
      input bit we, input bit bs, input logic [14:0] a, input int st,
      input bit es, input bit er, input bit eb);
    return {4'(rq), ce, oe, we, bs, a, 3'(st), es, er, eb};
  endfunction

  localparam logic [VW-1:0] VEC [0:47] = '{
    // R2 store run, mixed strobes; R3 store pulse; R8 blocked window
    v(2,1,0,0,0,15'h0E38,1,0,0,0), v(2,1,0,0,0,15'h31C7,2,0,0,0),
    v(7,0,1,0,0,15'h03E0,3,0,0,0), v(1,0,0,0,0,15'h7FFF,3,0,0,0),
    v(2,1,0,0,0,15'h3C1F,4,0,0,0), v(7,0,1,0,0,15'h303F,5,0,0,0),
    v(3,1,0,0,0,15'h0FC0,0,1,0,1), v(8,1,0,0,0,15'h0E38,0,0,0,1),
    v(8,0,0,0,1,15'h0000,0,0,0,1), v(8,0,0,0,0,15'h0000,0,0,0,0),
    // R4 recall run, both strobes at once (R7)
    v(7,1,1,0,0,15'h0E38,1,0,0,0), v(2,1,1,0,0,15'h31C7,2,0,0,0),
    v(2,1,0,0,0,15'h03E0,3,0,0,0), v(2,1,0,0,0,15'h3C1F,4,0,0,0),
    v(2,1,0,0,0,15'h303F,5,0,0,0), v(4,0,1,0,0,15'h0C63,0,0,1,1),
    v(8,0,0,0,1,15'h0000,0,0,0,1), v(8,0,0,0,0,15'h0000,0,0,0,0),
    // R5 write aborts mid-run
    v(2,1,0,0,0,15'h0E38,1,0,0,0), v(2,1,0,0,0,15'h31C7,2,0,0,0),
    v(5,1,0,1,0,15'h03E0,0,0,0,0),
    // R6 mismatch and restart at first address
    v(2,1,0,0,0,15'h0E38,1,0,0,0), v(6,1,0,0,0,15'h1234,0,0,0,0),
    v(2,1,0,0,0,15'h0E38,1,0,0,0), v(2,1,0,0,0,15'h31C7,2,0,0,0),
    v(6,1,0,0,0,15'h0E38,1,0,0,0), v(2,1,0,0,0,15'h31C7,2,0,0,0),
    v(2,1,0,0,0,15'h03E0,3,0,0,0), v(2,1,0,0,0,15'h3C1F,4,0,0,0),
    v(2,1,0,0,0,15'h303F,5,0,0,0), v(6,1,0,0,0,15'h0E38,1,0,0,0),
    v(6,1,0,0,0,15'h0000,0,0,0,0),
    // R6 wrong sixth address
    v(2,1,0,0,0,15'h0E38,1,0,0,0), v(2,1,0,0,0,15'h31C7,2,0,0,0),
    v(2,1,0,0,0,15'h03E0,3,0,0,0), v(2,1,0,0,0,15'h3C1F,4,0,0,0),
    v(2,1,0,0,0,15'h303F,5,0,0,0), v(6,1,0,0,0,15'h0FC1,0,0,0,0),
    // R5 write at the store address at step 5
    v(2,1,0,0,0,15'h0E38,1,0,0,0), v(2,1,0,0,0,15'h31C7,2,0,0,0),
    v(2,1,0,0,0,15'h03E0,3,0,0,0), v(2,1,0,0,0,15'h3C1F,4,0,0,0),
    v(2,1,0,0,0,15'h303F,5,0,0,0), v(5,1,0,1,0,15'h0FC0,0,0,0,0),
    // R9 busy kills a run and ignores accesses
    v(2,1,0,0,0,15'h0E38,1,0,0,0), v(2,1,0,0,0,15'h31C7,2,0,0,0),
    v(9,1,0,0,1,15'h03E0,0,0,0,0), v(9,1,0,0,0,15'h03E0,0,0,0,0)
  };

  task automatic check(input string rq, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {step,store,recall,block} got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic apply(input bit ce, input bit oe, input bit we, input bit bs,
                       input logic [14:0] a);
    ce_acc_i = ce; oe_acc_i = oe; we_i = we; busy_i = bs; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    ce_acc_i = 0; oe_acc_i = 0; we_i = 0; busy_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", {step_o, store_req_o, recall_req_o, io_block_o}, 6'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < 48; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      apply(e[24], e[23], e[22], e[21], e[20:6]);
      check($sformatf("R%0d vec %0d", e[28:25], i),
            {step_o, store_req_o, recall_req_o, io_block_o}, e[5:0]);
    end
    // R10 reset mid-run clears at once
    apply(1, 0, 0, 0, 15'h0E38);
    apply(1, 0, 0, 0, 15'h31C7);
    apply(0, 1, 0, 0, 15'h03E0);
    check("R10 pre", {step_o, store_req_o, recall_req_o, io_block_o}, {3'd3, 3'b000});
    #1 rst_ni = 1'b0;
    #1 check("R10", {step_o, store_req_o, recall_req_o, io_block_o}, 6'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 idle cycles keep the count
    apply(1, 0, 0, 0, 15'h0E38);
    repeat (4) @(negedge clk_i);
    check("R1", {step_o, store_req_o, recall_req_o, io_block_o}, {3'd1, 3'b000});
    // R3 pulse lasts one cycle
    apply(1, 0, 0, 0, 15'h31C7);
    apply(1, 0, 0, 0, 15'h03E0);
    apply(1, 0, 0, 0, 15'h3C1F);
    apply(1, 0, 0, 0, 15'h303F);
    apply(1, 0, 0, 0, 15'h0FC0);
    check("R3", {step_o, store_req_o, recall_req_o, io_block_o}, {3'd0, 3'b101});
    @(negedge clk_i);
    check("R3", {step_o, store_req_o, recall_req_o, io_block_o}, {3'd0, 3'b001});
    // R8 block held without busy
    repeat (5) @(negedge clk_i);
    check("R8", {step_o, store_req_o, recall_req_o, io_block_o}, {3'd0, 3'b001});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule